// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block decides, for one issuing load, whether its data can be taken from an older store that is still waiting in the store queue. The load presents its address, its byte count, the queue position one past its youngest older store, its load-queue index and its sequence number. The block walks the older stores from youngest to oldest and stops at the writeback pointer. The first store whose bytes touch the load decides the outcome. A store that holds every byte of the load forwards them. A store that holds only some of them forces a replay stall. When no store touches the load, the load goes to memory.

A forwarded value is the load-size slice of the store's 16-byte buffer that starts at the difference between the two addresses. The result is registered and appears one cycle after the request. The block also keeps a single stall record. That record holds the oldest load that met a partial overlap and the sequence number of the store blocking it. The record is released when that store reports completion.

Top module: `st_fwd_unit`

## Requirements
- R1: The scanned entries run from slot `ld_sq_idx-1` down to slot `wb_ptr` inclusive, wrapping modulo the queue depth. When `ld_sq_idx` equals `wb_ptr`, or when `ld_sq_none` is high, no entry is scanned.
- R2: An entry whose size is 0 or whose uncacheable flag is set never decides the result, even if its address range overlaps the load.
- R3: The result is forward (`res_kind` = 1) when the deciding store satisfies load address >= store address and load address + load size <= store address + store size.
- R4: On a forward, result byte j (bits 8j+7:8j) equals store buffer byte (load address - store address + j), where buffer byte i sits at bits 8i+7:8i. This holds for j below the load size, and result bytes at or above the load size are zero.
- R5: Among scanned entries, the youngest one that overlaps the load decides the result. Older entries have no effect on it.
- R6: An overlap (load start < store end and load end > store start) without full coverage gives stall (`res_kind` = 2) with `res_data` zero.
- R7: When no scanned entry overlaps, the result is memory (`res_kind` = 3). Ranges that only touch end-to-start do not overlap.
- R8: `res_valid`, `res_kind`, `res_data` and `res_lq_idx` are registered. They reflect the request of the previous cycle. With no request, `res_valid` is 0 and `res_kind` is 0.
- R9: A stall result writes the record (blocking store sequence, load index) when no record is active or when the new load's sequence number is smaller than the recorded load's. Otherwise the record is kept.
- R10: The record is released when `st_done` is high and `st_done_seq` equals the recorded store sequence. A stall result in that same cycle takes the record regardless of age.
- R11: After reset, `res_valid` and `stall_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_req | input | 1 | A load presents its address this cycle |
| ld_addr | input | ADDR_W | Load start address |
| ld_size | input | LSZ_W | Load byte count, 1..LD_BYTES |
| ld_sq_idx | input | IDX_W | Queue slot one past the load's youngest older store |
| ld_sq_none | input | 1 | The load has no older store to check |
| ld_lq_idx | input | LQ_IDX_W | Load-queue index of the load |
| ld_seq | input | SEQ_W | Load sequence number, smaller is older |
| wb_ptr | input | IDX_W | Oldest store not yet written back |
| sq_addr | input | SQ_DEPTH*ADDR_W | Start address of each store slot |
| sq_size | input | SQ_DEPTH*SSZ_W | Byte count of each store slot, 0..BUF_BYTES |
| sq_nocache | input | SQ_DEPTH | Uncacheable flag per slot |
| sq_data | input | SQ_DEPTH*BUF_BYTES*8 | Data buffer of each slot |
| sq_seq | input | SQ_DEPTH*SEQ_W | Sequence number of each slot |
| st_done | input | 1 | A store has completed its writeback |
| st_done_seq | input | SEQ_W | Sequence number of the completed store |
| res_valid | output | 1 | Result for last cycle's load |
| res_kind | output | 2 | 0 none, 1 forward, 2 stall, 3 memory |
| res_data | output | LD_BYTES*8 | Forwarded bytes, zero unless forward |
| res_lq_idx | output | LQ_IDX_W | Load-queue index of the result |
| stall_active | output | 1 | A stall record is held |
| stall_st_seq | output | SEQ_W | Sequence number of the blocking store |
| stall_lq_idx | output | LQ_IDX_W | Load-queue index of the stalled load |

## Verification
A stall from a new load and the release of the current record can land on the same clock edge. The block has to hand the record to the new load, even when that load is younger than the one being released. The bench sets up a record with a partial overlap. It then issues a younger partially overlapping load in the same cycle as the completion of the recorded store, and expects the record to name the new store and load index. The random phase also pulses completion with the recorded sequence about half the time while loads issue. A bench model that applies both rules in one step judges every such collision.

// File: rtl/st_fwd_pkg.sv
package st_fwd_pkg;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_FWD   = 2'd1,
        RES_STALL = 2'd2,
        RES_MEM   = 2'd3
    } res_kind_e;

    typedef struct packed {
        logic hit;   // entry overlaps the load and is eligible
        logic full;  // entry holds every byte of the load
    } slot_match_t;

    // Sequence numbers are plain unsigned; smaller means older.
    function automatic logic seq_older(input logic [63:0] a, input logic [63:0] b);
        return a < b;
    endfunction

endpackage

// File: rtl/st_fwd_match.sv
module st_fwd_match
    import st_fwd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SSZ_W  = 5,
    parameter int LSZ_W  = 4
) (
    input  logic              in_window,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [LSZ_W-1:0]  ld_size,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [SSZ_W-1:0]  st_size,
    input  logic              st_nocache,
    output slot_match_t       m
);
    localparam int EW = ADDR_W + 1;

    logic [EW-1:0] ld_lo, ld_hi, st_lo, st_hi;
    logic          eligible, overlap, covers;

    always_comb begin
        ld_lo    = {1'b0, ld_addr};
        ld_hi    = ld_lo + EW'(ld_size);
        st_lo    = {1'b0, st_addr};
        st_hi    = st_lo + EW'(st_size);
        eligible = in_window && (st_size != '0) && !st_nocache;
        overlap  = (ld_lo < st_hi) && (ld_hi > st_lo);
        covers   = (ld_lo >= st_lo) && (ld_hi <= st_hi);
        m.hit    = eligible && overlap;
        m.full   = eligible && overlap && covers;
    end

endmodule

// File: rtl/st_fwd_extract.sv
module st_fwd_extract #(
    parameter int BUF_BYTES = 16,
    parameter int LD_BYTES  = 8,
    parameter int OFF_W     = 4,
    parameter int LSZ_W     = 4
) (
    input  logic [BUF_BYTES*8-1:0] src,
    input  logic [OFF_W-1:0]       offset,
    input  logic [LSZ_W-1:0]       ld_size,
    output logic [LD_BYTES*8-1:0]  dout
);
    always_comb begin
        dout = '0;
        for (int j = 0; j < LD_BYTES; j++) begin
            int pos;
            pos = int'(offset) + j;
            if (j < int'(ld_size) && pos < BUF_BYTES)
                dout[8*j +: 8] = src[8*pos +: 8];
        end
    end

endmodule

// File: rtl/st_fwd_stall.sv
module st_fwd_stall
    import st_fwd_pkg::*;
#(
    parameter int SEQ_W    = 16,
    parameter int LQ_IDX_W = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                claim,
    input  logic [SEQ_W-1:0]    cand_ld_seq,
    input  logic [SEQ_W-1:0]    cand_st_seq,
    input  logic [LQ_IDX_W-1:0] cand_lq_idx,
    input  logic                done,
    input  logic [SEQ_W-1:0]    done_seq,
    output logic                active,
    output logic [SEQ_W-1:0]    rec_st_seq,
    output logic [LQ_IDX_W-1:0] rec_lq_idx
);
    logic [SEQ_W-1:0] rec_ld_seq;
    logic             release_now, take;

    always_comb begin
        release_now = active && done && (done_seq == rec_st_seq);
        take = claim && (!active || release_now ||
                         seq_older(64'(cand_ld_seq), 64'(rec_ld_seq)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active     <= 1'b0;
            rec_st_seq <= '0;
            rec_ld_seq <= '0;
            rec_lq_idx <= '0;
        end else if (take) begin
            active     <= 1'b1;
            rec_st_seq <= cand_st_seq;
            rec_ld_seq <= cand_ld_seq;
            rec_lq_idx <= cand_lq_idx;
        end else if (release_now) begin
            active <= 1'b0;
        end
    end

endmodule

// File: rtl/st_fwd_unit.sv
module st_fwd_unit
    import st_fwd_pkg::*;
#(
    parameter int SQ_DEPTH  = 8,
    parameter int ADDR_W    = 16,
    parameter int SEQ_W     = 16,
    parameter int LQ_IDX_W  = 5,
    parameter int BUF_BYTES = 16,
    parameter int LD_BYTES  = 8,
    localparam int IDX_W    = $clog2(SQ_DEPTH),
    localparam int SSZ_W    = $clog2(BUF_BYTES) + 1,
    localparam int LSZ_W    = $clog2(LD_BYTES) + 1,
    localparam int BUF_W    = BUF_BYTES * 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         ld_req,
    input  logic [ADDR_W-1:0]            ld_addr,
    input  logic [LSZ_W-1:0]             ld_size,
    input  logic [IDX_W-1:0]             ld_sq_idx,
    input  logic                         ld_sq_none,
    input  logic [LQ_IDX_W-1:0]          ld_lq_idx,
    input  logic [SEQ_W-1:0]             ld_seq,
    input  logic [IDX_W-1:0]             wb_ptr,
    input  logic [SQ_DEPTH*ADDR_W-1:0]   sq_addr,
    input  logic [SQ_DEPTH*SSZ_W-1:0]    sq_size,
    input  logic [SQ_DEPTH-1:0]          sq_nocache,
    input  logic [SQ_DEPTH*BUF_W-1:0]    sq_data,
    input  logic [SQ_DEPTH*SEQ_W-1:0]    sq_seq,
    input  logic                         st_done,
    input  logic [SEQ_W-1:0]             st_done_seq,
    output logic                         res_valid,
    output logic [1:0]                   res_kind,
    output logic [LD_BYTES*8-1:0]        res_data,
    output logic [LQ_IDX_W-1:0]          res_lq_idx,
    output logic                         stall_active,
    output logic [SEQ_W-1:0]             stall_st_seq,
    output logic [LQ_IDX_W-1:0]          stall_lq_idx
);
    localparam int OFF_W = $clog2(BUF_BYTES);

    logic [IDX_W-1:0]    win_len;
    logic [IDX_W-1:0]    slot_idx [SQ_DEPTH];
    slot_match_t         match    [SQ_DEPTH];

    assign win_len = ld_sq_idx - wb_ptr;

    // Position k holds the k-th store counting back from the youngest older one.
    for (genvar k = 0; k < SQ_DEPTH; k++) begin : g_scan
        logic in_win;
        assign slot_idx[k] = ld_sq_idx - IDX_W'(k + 1);
        assign in_win      = !ld_sq_none && (IDX_W'(k) < win_len);

        st_fwd_match #(
            .ADDR_W (ADDR_W),
            .SSZ_W  (SSZ_W),
            .LSZ_W  (LSZ_W)
        ) u_match (
            .in_window  (in_win),
            .ld_addr    (ld_addr),
            .ld_size    (ld_size),
            .st_addr    (sq_addr[slot_idx[k]*ADDR_W +: ADDR_W]),
            .st_size    (sq_size[slot_idx[k]*SSZ_W +: SSZ_W]),
            .st_nocache (sq_nocache[slot_idx[k]]),
            .m          (match[k])
        );
    end

    logic              found, sel_full;
    logic [IDX_W-1:0]  sel;
    res_kind_e         kind_d;
    logic [ADDR_W-1:0] sel_addr;
    logic [SEQ_W-1:0]  sel_seq;
    logic [OFF_W-1:0]  sel_off;
    logic [BUF_W-1:0]  sel_buf;
    logic [LD_BYTES*8-1:0] fwd_bytes;

    // Youngest eligible overlap wins.
    always_comb begin
        found    = 1'b0;
        sel_full = 1'b0;
        sel      = '0;
        for (int k = 0; k < SQ_DEPTH; k++) begin
            if (!found && match[k].hit) begin
                found    = 1'b1;
                sel      = slot_idx[k];
                sel_full = match[k].full;
            end
        end
        if (!found)        kind_d = RES_MEM;
        else if (sel_full) kind_d = RES_FWD;
        else               kind_d = RES_STALL;
        sel_addr = sq_addr[sel*ADDR_W +: ADDR_W];
        sel_seq  = sq_seq[sel*SEQ_W +: SEQ_W];
        sel_buf  = sq_data[sel*BUF_W +: BUF_W];
        sel_off  = OFF_W'(ld_addr - sel_addr);
    end

    st_fwd_extract #(
        .BUF_BYTES (BUF_BYTES),
        .LD_BYTES  (LD_BYTES),
        .OFF_W     (OFF_W),
        .LSZ_W     (LSZ_W)
    ) u_extract (
        .src     (sel_buf),
        .offset  (sel_off),
        .ld_size (ld_size),
        .dout    (fwd_bytes)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_kind   <= RES_NONE;
            res_data   <= '0;
            res_lq_idx <= '0;
        end else begin
            res_valid  <= ld_req;
            res_kind   <= ld_req ? kind_d : RES_NONE;
            res_data   <= (ld_req && kind_d == RES_FWD) ? fwd_bytes : '0;
            res_lq_idx <= ld_req ? ld_lq_idx : '0;
        end
    end

    st_fwd_stall #(
        .SEQ_W    (SEQ_W),
        .LQ_IDX_W (LQ_IDX_W)
    ) u_stall (
        .clk         (clk),
        .rst         (rst),
        .claim       (ld_req && kind_d == RES_STALL),
        .cand_ld_seq (ld_seq),
        .cand_st_seq (sel_seq),
        .cand_lq_idx (ld_lq_idx),
        .done        (st_done),
        .done_seq    (st_done_seq),
        .active      (stall_active),
        .rec_st_seq  (stall_st_seq),
        .rec_lq_idx  (stall_lq_idx)
    );

endmodule

// File: rtl/st_fwd_checker.sv
module st_fwd_checker #(
    parameter int SEQ_W = 16,
    parameter int DW    = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             ld_req,
    input logic             st_done,
    input logic [SEQ_W-1:0] st_done_seq,
    input logic             res_valid,
    input logic [1:0]       res_kind,
    input logic [DW-1:0]    res_data,
    input logic             stall_active,
    input logic [SEQ_W-1:0] stall_st_seq
);
    AST_RESULT_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        ld_req |=> res_valid); // R8
    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (rst)
        !ld_req |=> !res_valid); // R8
    AST_IDLE_KIND_ZERO: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> res_kind == 2'd0); // R8
    AST_STALL_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind == 2'd2) |-> res_data == '0); // R6
    AST_STALL_RECORDED: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_kind == 2'd2) |-> stall_active); // R9
    AST_NO_SET_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!stall_active && !ld_req) |=> !stall_active); // R9
    AST_RECORD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (stall_active && !ld_req && !st_done) |=> (stall_active && $stable(stall_st_seq))); // R9
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (stall_active && !st_done) |=> stall_active); // R10
    AST_STALL_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (stall_active && st_done && st_done_seq == stall_st_seq && !ld_req) |=> !stall_active); // R10
endmodule

bind st_fwd_unit st_fwd_checker #(
    .SEQ_W (SEQ_W),
    .DW    (LD_BYTES*8)
) u_st_fwd_checker (
    .clk          (clk),
    .rst          (rst),
    .ld_req       (ld_req),
    .st_done      (st_done),
    .st_done_seq  (st_done_seq),
    .res_valid    (res_valid),
    .res_kind     (res_kind),
    .res_data     (res_data),
    .stall_active (stall_active),
    .stall_st_seq (stall_st_seq)
);

// File: tb/test_st_fwd_unit.sv
module test_st_fwd_unit;
    localparam int D = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic        ld_req = 1'b0;
    logic [15:0] ld_addr = '0;
    logic [3:0]  ld_size = 4'd1;
    logic [2:0]  ld_sq_idx = '0;
    logic        ld_sq_none = 1'b0;
    logic [4:0]  ld_lq_idx = '0;
    logic [15:0] ld_seq = '0;
    logic [2:0]  wb_ptr = '0;
    logic        st_done = 1'b0;
    logic [15:0] st_done_seq = '0;

    logic [15:0]  b_addr [D];
    logic [4:0]   b_size [D];
    logic         b_nc   [D];
    logic [127:0] b_data [D];
    logic [15:0]  b_seq  [D];

    logic [D*16-1:0]  sq_addr;
    logic [D*5-1:0]   sq_size;
    logic [D-1:0]     sq_nocache;
    logic [D*128-1:0] sq_data;
    logic [D*16-1:0]  sq_seq;

    always_comb begin
        for (int i = 0; i < D; i++) begin
            sq_addr[i*16 +: 16]   = b_addr[i];
            sq_size[i*5 +: 5]     = b_size[i];
            sq_nocache[i]         = b_nc[i];
            sq_data[i*128 +: 128] = b_data[i];
            sq_seq[i*16 +: 16]    = b_seq[i];
        end
    end

    logic        res_valid, stall_active;
    logic [1:0]  res_kind;
    logic [63:0] res_data;
    logic [4:0]  res_lq_idx, stall_lq_idx;
    logic [15:0] stall_st_seq;

    st_fwd_unit i_st_fwd_unit (
        .clk(clk), .rst(rst), .ld_req(ld_req), .ld_addr(ld_addr), .ld_size(ld_size),
        .ld_sq_idx(ld_sq_idx), .ld_sq_none(ld_sq_none), .ld_lq_idx(ld_lq_idx),
        .ld_seq(ld_seq), .wb_ptr(wb_ptr), .sq_addr(sq_addr), .sq_size(sq_size),
        .sq_nocache(sq_nocache), .sq_data(sq_data), .sq_seq(sq_seq),
        .st_done(st_done), .st_done_seq(st_done_seq), .res_valid(res_valid),
        .res_kind(res_kind), .res_data(res_data), .res_lq_idx(res_lq_idx),
        .stall_active(stall_active), .stall_st_seq(stall_st_seq),
        .stall_lq_idx(stall_lq_idx)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // model of the stall record
    logic        m_act = 1'b0;
    logic [15:0] m_stseq = '0, m_ldseq = '0;
    logic [4:0]  m_lq = '0;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Walk the older stores like the requirement text describes.
    function automatic void model_res(output logic [1:0] k, output logic [63:0] d,
                                      output logic [15:0] hseq);
        int idx, ls, le, ss, se, off;
        k = 2'd3; d = '0; hseq = '0;
        idx = int'(ld_sq_idx);
        if (!ld_sq_none) begin
            while (idx != int'(wb_ptr)) begin
                idx = (idx + D - 1) % D;
                if (b_size[idx] == 0 || b_nc[idx]) continue;
                ls = int'(ld_addr); le = ls + int'(ld_size);
                ss = int'(b_addr[idx]); se = ss + int'(b_size[idx]);
                if (ls >= ss && le <= se) begin
                    k = 2'd1; off = ls - ss;
                    for (int j = 0; j < int'(ld_size); j++)
                        d[8*j +: 8] = b_data[idx][8*(off+j) +: 8];
                    break;
                end else if (ls < se && le > ss) begin
                    k = 2'd2; hseq = b_seq[idx];
                    break;
                end
            end
        end
    endfunction

    // One clock: compute expectations, clock, compare.
    task automatic cycle();
        logic [1:0]  ek;
        logic [63:0] ed;
        logic [15:0] hs;
        logic        rel;
        logic [4:0]  elq;
        model_res(ek, ed, hs);
        rel = st_done && m_act && (st_done_seq == m_stseq);
        if (ld_req && ek == 2'd2 && (!m_act || rel || ld_seq < m_ldseq)) begin
            m_act = 1'b1; m_stseq = hs; m_ldseq = ld_seq; m_lq = ld_lq_idx;
        end else if (rel) begin
            m_act = 1'b0;
        end
        elq = ld_lq_idx;
        @(posedge clk);
        #1;
        chk("R8 valid", 128'(res_valid), 128'(ld_req));
        chk("R5 kind", 128'(res_kind), ld_req ? 128'(ek) : 128'd0);
        chk("R4 data", 128'(res_data), (ld_req && ek == 2'd1) ? 128'(ed) : 128'd0);
        if (ld_req) chk("R8 lq index", 128'(res_lq_idx), 128'(elq));
        chk("R9 stall active", 128'(stall_active), 128'(m_act));
        if (m_act) begin
            chk("R9 stall store seq", 128'(stall_st_seq), 128'(m_stseq));
            chk("R10 stall lq index", 128'(stall_lq_idx), 128'(m_lq));
        end
    endtask

    task automatic clear_sq();
        for (int i = 0; i < D; i++) begin
            b_addr[i] = '0; b_size[i] = '0; b_nc[i] = 1'b0; b_data[i] = '0; b_seq[i] = '0;
        end
    endtask

    task automatic set_st(input int s, input logic [15:0] a, input logic [4:0] sz,
                          input logic nc, input logic [15:0] sq, input logic [7:0] fill);
        b_addr[s] = a; b_size[s] = sz; b_nc[s] = nc; b_seq[s] = sq;
        for (int i = 0; i < 16; i++) b_data[s][8*i +: 8] = fill + 8'(i);
    endtask

    task automatic load(input logic [15:0] a, input logic [3:0] sz, input logic [2:0] sqi,
                        input logic [2:0] wb, input logic [4:0] lq, input logic [15:0] sq);
        ld_req = 1'b1; ld_addr = a; ld_size = sz; ld_sq_idx = sqi; wb_ptr = wb;
        ld_lq_idx = lq; ld_seq = sq; ld_sq_none = 1'b0;
    endtask

    task automatic exp_res(input string tag, input logic [1:0] k, input logic [63:0] d);
        chk(tag, 128'(res_kind), 128'(k));
        chk(tag, 128'(res_data), 128'(d));
    endtask

    initial begin
        #(8 * 190000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        clear_sq();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        chk("R11 reset valid", 128'(res_valid), 128'd0);
        chk("R11 reset stall", 128'(stall_active), 128'd0);

        // R1: empty window sends a covered load to memory
        set_st(2, 16'h0200, 5'd16, 1'b0, 16'h0010, 8'h10);
        load(16'h0204, 4'd4, 3'd3, 3'd3, 5'd1, 16'd500);
        cycle();
        exp_res("R1 empty window", 2'd3, 64'd0);
        ld_sq_none = 1'b1; cycle();
        exp_res("R1 no store flag", 2'd3, 64'd0);

        // R1: wrapped window 0,7,6; slot 1 (own index) and slot 5 outside
        clear_sq();
        set_st(7, 16'h0300, 5'd8, 1'b0, 16'h0020, 8'h70);
        set_st(1, 16'h0300, 5'd8, 1'b0, 16'h0021, 8'hE0);
        set_st(5, 16'h0300, 5'd8, 1'b0, 16'h0022, 8'hC0);
        load(16'h0300, 4'd2, 3'd1, 3'd6, 5'd2, 16'd500);
        cycle();
        exp_res("R1 wrapped window", 2'd1, 64'h7170);

        // R2: uncacheable and zero-size entries skipped
        clear_sq();
        set_st(2, 16'h0400, 5'd8, 1'b1, 16'h0030, 8'hA0);
        set_st(1, 16'h0400, 5'd0, 1'b0, 16'h0031, 8'hB0);
        set_st(0, 16'h0400, 5'd8, 1'b0, 16'h0032, 8'h30);
        load(16'h0401, 4'd1, 3'd3, 3'd0, 5'd3, 16'd500);
        cycle();
        exp_res("R2 skipped entries", 2'd1, 64'h31);

        // R5: youngest of two covering stores wins
        set_st(2, 16'h0400, 5'd8, 1'b0, 16'h0030, 8'hA0);
        cycle();
        exp_res("R5 youngest wins", 2'd1, 64'hA1);

        // R3 R4: offset extraction and end-aligned full cover
        clear_sq();
        set_st(0, 16'h0200, 5'd16, 1'b0, 16'h0040, 8'hA0);
        load(16'h0209, 4'd4, 3'd1, 3'd0, 5'd4, 16'd500);
        cycle();
        exp_res("R4 offset bytes", 2'd1, 64'hACABAAA9);
        load(16'h020C, 4'd4, 3'd1, 3'd0, 5'd4, 16'd500);
        cycle();
        exp_res("R3 end aligned", 2'd1, 64'hAFAEADAC);

        // R7: touching ranges do not overlap
        load(16'h0210, 4'd4, 3'd1, 3'd0, 5'd4, 16'd500);
        cycle();
        exp_res("R7 after store", 2'd3, 64'd0);
        load(16'h01FC, 4'd4, 3'd1, 3'd0, 5'd4, 16'd500);
        cycle();
        exp_res("R7 before store", 2'd3, 64'd0);

        // R6: partial overlap stalls and records
        load(16'h020E, 4'd4, 3'd1, 3'd0, 5'd2, 16'd100);
        cycle();
        exp_res("R6 partial", 2'd2, 64'd0);
        chk("R9 first record", 128'({stall_active, stall_st_seq, stall_lq_idx}),
            128'({1'b1, 16'h0040, 5'd2}));

        // R9: younger load keeps the record, older load replaces it
        b_seq[0] = 16'h0055;
        load(16'h020E, 4'd4, 3'd1, 3'd0, 5'd5, 16'd200);
        cycle();
        chk("R9 younger kept", 128'({stall_st_seq, stall_lq_idx}), 128'({16'h0040, 5'd2}));
        load(16'h020E, 4'd4, 3'd1, 3'd0, 5'd6, 16'd50);
        cycle();
        chk("R9 older replaces", 128'({stall_st_seq, stall_lq_idx}), 128'({16'h0055, 5'd6}));

        // R10: wrong seq keeps, matching seq releases
        ld_req = 1'b0; st_done = 1'b1; st_done_seq = 16'h0099;
        cycle();
        chk("R10 wrong seq keeps", 128'(stall_active), 128'd1);
        chk("R8 idle kind", 128'(res_kind), 128'd0);
        st_done_seq = 16'h0055;
        cycle();
        chk("R10 release", 128'(stall_active), 128'd0);
        st_done = 1'b0;

        // R10: release and a younger stall in the same cycle
        b_seq[0] = 16'h0077;
        load(16'h020E, 4'd4, 3'd1, 3'd0, 5'd3, 16'd300);
        cycle();
        b_seq[0] = 16'h0088;
        load(16'h020E, 4'd4, 3'd1, 3'd0, 5'd9, 16'd900);
        st_done = 1'b1; st_done_seq = 16'h0077;
        cycle();
        chk("R10 same cycle takeover", 128'({stall_active, stall_st_seq, stall_lq_idx}),
            128'({1'b1, 16'h0088, 5'd9}));
        st_done = 1'b0;

        // Random phase
        void'($urandom(32'h5EED));
        for (int n = 0; n < 4000; n++) begin
            for (int i = 0; i < D; i++) begin
                b_addr[i] = 16'h0100 + 16'($urandom % 48);
                b_size[i] = 5'($urandom % 17);
                b_nc[i]   = ($urandom % 10) == 0;
                b_data[i] = {$urandom, $urandom, $urandom, $urandom};
                b_seq[i]  = 16'($urandom);
            end
            ld_req     = ($urandom % 5) != 0;
            ld_addr    = 16'h0100 + 16'($urandom % 56);
            ld_size    = 4'(1 + $urandom % 8);
            ld_sq_idx  = 3'($urandom);
            wb_ptr     = 3'($urandom);
            ld_sq_none = ($urandom % 16) == 0;
            ld_lq_idx  = 5'($urandom);
            ld_seq     = 16'($urandom);
            st_done    = ($urandom % 4) == 0;
            st_done_seq = ($urandom % 2) ? m_stseq : 16'($urandom);
            cycle();
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule